// File: doc/BRIEF.md
# Wide Register Host Access Buffer

This block sits between a 32-bit host register port and two kinds of wide storage: a bank of 128-bit control registers, each of four dwords, and an SRAM of 64-bit words, each of two dwords. A wide value cannot be moved in one host access, so the block splits the work. Writes are gathered dword by dword in a staging buffer, and the backing register or SRAM word changes only when every dword of it has arrived. Reads take a snapshot of the whole wide value, so a host reading it dword by dword sees one consistent value.

The host address is a byte address. Bit 11 selects the region: 0 for the registers and 1 for the SRAM. A register dword sits at `idx*16 + dword*4`. An SRAM dword sits at `0x800 + idx*8 + dword*4`. One register dword address is configured to skip staging, so a single write to it takes effect at once. One register index is read-to-clear: taking its snapshot zeroes it.

Top module: `wide_reg_gather`

## Requirements
- R1: A write to a dword of a 128-bit register (region bit 11 = 0, dword from address bits [3:2], index from bits [6:4]) goes to staging, and the register keeps its old value until all four dwords have been written. The register holds the full staged value from the cycle after the last dword is written.
- R2: Dwords may arrive in any order. A second write to an already staged dword replaces the staged value.
- R3: SRAM words (bit 11 = 1, dword from address bit [2], index from bits [6:3]) are gathered the same way and are committed once both dwords have been written.
- R4: A non-bypass write to a different register or word than the one partly staged discards the staged dwords and starts a new gather. `merge_err` is high for exactly the one cycle after that write.
- R5: After a commit the staging mask is empty, so the next write starts a fresh gather and does not raise `merge_err`.
- R6: A read of dword 0, or of any dword of a different register or word than the current snapshot, latches the whole live value into the snapshot. In the cycle after every read, `host_rvalid` is 1 and `host_rdata` holds the requested dword. In every other cycle `host_rvalid` is 0.
- R7: A read of a nonzero dword of the register or word already held in the snapshot returns snapshot data, even if the backing value has been written since.
- R8: The register at index `RC_INDEX` (default 6) is cleared to zero when its snapshot is taken. Later reads of its higher dwords from the snapshot still return the values it held before the clear.
- R9: A write to `BYPASS_ADDR` (default 0x070, register 7 dword 0) updates that dword on the next cycle and leaves the staging buffer unchanged.
- R10: After reset all registers read zero, `host_rdata`, `host_rvalid` and `merge_err` are 0, and no snapshot is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_rd | input | 1 | Host read strobe, one access per cycle |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 32 | Host write dword |
| host_rdata | output | 32 | Read dword, valid with host_rvalid |
| host_rvalid | output | 1 | High the cycle after a read |
| merge_err | output | 1 | Pulse: a partial gather was discarded |

## Verification
The assertions assume that the host never raises `host_wr` and `host_rd` in the same cycle. A simultaneous read and write would make the snapshot and commit order ambiguous. The checker states this assumption as a property. The bench keeps to it by issuing one access per task call and dropping both strobes when idle. Random addresses are built from valid region, index and dword fields, so they never fall outside the sized register bank or SRAM. Every SRAM word is written before it is read, so no reference value is unknown.

// File: rtl/wrg_pkg.sv
package wrg_pkg;
  typedef enum logic {REGION_CSR = 1'b0, REGION_SRAM = 1'b1} region_e;

  function automatic logic [3:0] full_mask(input logic region);
    return (region == REGION_SRAM) ? 4'b0011 : 4'b1111;
  endfunction
endpackage

// File: rtl/wrg_addr_dec.sv
module wrg_addr_dec #(
  parameter int ADDR_W     = 12,
  parameter int CSR_IDX_W  = 3,
  parameter int SRAM_IDX_W = 4,
  parameter int IDX_W      = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              region_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [1:0]        dword_o
);
  import wrg_pkg::*;

  logic unused_addr;
  assign unused_addr = ^addr_i;

  always_comb begin
    region_o = addr_i[ADDR_W-1];
    if (region_o == REGION_SRAM) begin
      idx_o   = IDX_W'(addr_i[3 +: SRAM_IDX_W]);
      dword_o = {1'b0, addr_i[2]};
    end else begin
      idx_o   = IDX_W'(addr_i[4 +: CSR_IDX_W]);
      dword_o = addr_i[3:2];
    end
  end
endmodule

// File: rtl/wrg_write_gather.sv
module wrg_write_gather #(
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [1:0]       dword_i,
  input  logic [31:0]      wdata_i,
  output logic             commit_o,
  output logic [TAG_W-1:0] commit_tag_o,
  output logic [127:0]     commit_data_o,
  output logic             err_o
);
  import wrg_pkg::*;

  logic [3:0]       mask_q;
  logic [TAG_W-1:0] tag_q;
  logic [127:0]     data_q;
  logic             err_q;

  logic             hit;
  logic [3:0]       new_mask;
  logic [3:0]       need;
  logic [127:0]     new_data;

  always_comb begin
    hit      = (mask_q != 4'b0) && (tag_q == tag_i);
    new_mask = (hit ? mask_q : 4'b0) | (4'b0001 << dword_i);
    new_data = data_q;
    new_data[{dword_i, 5'b0} +: 32] = wdata_i;
    need     = full_mask(tag_i[TAG_W-1]);
    commit_o = wr_i && ((new_mask & need) == need);
  end

  assign commit_tag_o  = tag_i;
  assign commit_data_o = new_data;
  assign err_o         = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 4'b0;
      tag_q  <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= wr_i && (mask_q != 4'b0) && !hit;
      if (wr_i) begin
        tag_q  <= tag_i;
        data_q <= new_data;
        mask_q <= commit_o ? 4'b0 : new_mask;
      end
    end
  end
endmodule

// File: rtl/wrg_read_snap.sv
module wrg_read_snap #(
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [1:0]       dword_i,
  input  logic [127:0]     live_i,
  output logic             latch_o,
  output logic [31:0]      rdata_o,
  output logic             rvalid_o
);
  logic             valid_q;
  logic [TAG_W-1:0] tag_q;
  logic [127:0]     snap_q;

  assign latch_o = rd_i && (!valid_q || (tag_q != tag_i) || (dword_i == 2'd0));

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      tag_q    <= '0;
      snap_q   <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (latch_o) begin
        valid_q <= 1'b1;
        tag_q   <= tag_i;
        snap_q  <= live_i;
        rdata_o <= live_i[{dword_i, 5'b0} +: 32];
      end else if (rd_i) begin
        rdata_o <= snap_q[{dword_i, 5'b0} +: 32];
      end
    end
  end
endmodule

// File: rtl/wrg_store.sv
module wrg_store #(
  parameter int CSR_COUNT  = 8,
  parameter int SRAM_DEPTH = 16,
  parameter int CSR_IDX_W  = 3,
  parameter int SRAM_IDX_W = 4,
  parameter int IDX_W      = 4,
  parameter int RC_INDEX   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit_i,
  input  logic [IDX_W:0]     commit_tag_i,
  input  logic [127:0]       commit_data_i,
  input  logic               byp_wr_i,
  input  logic [CSR_IDX_W-1:0] byp_idx_i,
  input  logic [1:0]         byp_dword_i,
  input  logic [31:0]        byp_data_i,
  input  logic               rc_clr_i,
  input  logic [IDX_W:0]     rd_tag_i,
  output logic [127:0]       live_o
);
  import wrg_pkg::*;

  logic [127:0] csr_q  [CSR_COUNT];
  logic [63:0]  sram_q [SRAM_DEPTH];

  logic csr_commit;
  logic sram_commit;
  assign csr_commit  = commit_i && (commit_tag_i[IDX_W] == REGION_CSR);
  assign sram_commit = commit_i && (commit_tag_i[IDX_W] == REGION_SRAM);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CSR_COUNT; i++) csr_q[i] <= '0;
    end else begin
      if (rc_clr_i) csr_q[RC_INDEX] <= '0;
      if (csr_commit) csr_q[commit_tag_i[CSR_IDX_W-1:0]] <= commit_data_i;
      if (byp_wr_i) csr_q[byp_idx_i][{byp_dword_i, 5'b0} +: 32] <= byp_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (sram_commit) sram_q[commit_tag_i[SRAM_IDX_W-1:0]] <= commit_data_i[63:0];
  end

  always_comb begin
    if (rd_tag_i[IDX_W] == REGION_SRAM)
      live_o = {64'b0, sram_q[rd_tag_i[SRAM_IDX_W-1:0]]};
    else
      live_o = csr_q[rd_tag_i[CSR_IDX_W-1:0]];
  end
endmodule

// File: rtl/wide_reg_gather.sv
module wide_reg_gather #(
  parameter int              ADDR_W      = 12,
  parameter int              CSR_COUNT   = 8,
  parameter int              SRAM_DEPTH  = 16,
  parameter int              RC_INDEX    = 6,
  parameter logic [ADDR_W-1:0] BYPASS_ADDR = 12'h070
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_rvalid,
  output logic              merge_err
);
  localparam int CSR_IDX_W  = $clog2(CSR_COUNT);
  localparam int SRAM_IDX_W = $clog2(SRAM_DEPTH);
  localparam int IDX_W      = (CSR_IDX_W > SRAM_IDX_W) ? CSR_IDX_W : SRAM_IDX_W;
  localparam int TAG_W      = IDX_W + 1;
  localparam logic [TAG_W-1:0] RC_TAG = {1'b0, IDX_W'(RC_INDEX)};

  logic             region;
  logic [IDX_W-1:0] idx;
  logic [1:0]       dword;
  logic [TAG_W-1:0] tag;
  logic             byp_hit;
  logic             gather_commit;
  logic [TAG_W-1:0] commit_tag;
  logic [127:0]     commit_data;
  logic             snap_latch;
  logic [127:0]     live;

  wrg_addr_dec #(
    .ADDR_W(ADDR_W), .CSR_IDX_W(CSR_IDX_W), .SRAM_IDX_W(SRAM_IDX_W), .IDX_W(IDX_W)
  ) u_dec (
    .addr_i(host_addr), .region_o(region), .idx_o(idx), .dword_o(dword)
  );

  assign tag     = {region, idx};
  assign byp_hit = host_wr && (host_addr == BYPASS_ADDR);

  wrg_write_gather #(.TAG_W(TAG_W)) u_gather (
    .clk(clk), .rst(rst),
    .wr_i(host_wr && !byp_hit), .tag_i(tag), .dword_i(dword), .wdata_i(host_wdata),
    .commit_o(gather_commit), .commit_tag_o(commit_tag), .commit_data_o(commit_data),
    .err_o(merge_err)
  );

  wrg_read_snap #(.TAG_W(TAG_W)) u_snap (
    .clk(clk), .rst(rst),
    .rd_i(host_rd), .tag_i(tag), .dword_i(dword), .live_i(live),
    .latch_o(snap_latch), .rdata_o(host_rdata), .rvalid_o(host_rvalid)
  );

  wrg_store #(
    .CSR_COUNT(CSR_COUNT), .SRAM_DEPTH(SRAM_DEPTH), .CSR_IDX_W(CSR_IDX_W),
    .SRAM_IDX_W(SRAM_IDX_W), .IDX_W(IDX_W), .RC_INDEX(RC_INDEX)
  ) u_store (
    .clk(clk), .rst(rst),
    .commit_i(gather_commit), .commit_tag_i(commit_tag), .commit_data_i(commit_data),
    .byp_wr_i(byp_hit), .byp_idx_i(BYPASS_ADDR[4 +: CSR_IDX_W]),
    .byp_dword_i(BYPASS_ADDR[3:2]), .byp_data_i(host_wdata),
    .rc_clr_i(snap_latch && (tag == RC_TAG)),
    .rd_tag_i(tag), .live_o(live)
  );
endmodule

// File: rtl/wrg_chk.sv
module wrg_chk #(
  parameter int              ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] BYPASS_ADDR = 12'h070
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr,
  input logic              host_rd,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_rvalid,
  input logic              merge_err,
  input logic [3:0]        mask,
  input logic              commit
);
  // R6 (input assumption: one access per cycle)
  one_access_chk: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && host_rd));

  // R6
  rd_gives_rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> host_rvalid);

  // R6
  no_rd_no_rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> !host_rvalid);

  // R4
  err_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    merge_err |-> $past(host_wr));

  // R5
  mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> (mask == 4'b0));

  // R9
  bypass_keeps_stage_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && (host_addr == BYPASS_ADDR)) |=> $stable(mask));
endmodule

bind wide_reg_gather wrg_chk #(.ADDR_W(ADDR_W), .BYPASS_ADDR(BYPASS_ADDR)) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
  .host_rvalid(host_rvalid), .merge_err(merge_err),
  .mask(u_gather.mask_q), .commit(gather_commit)
);

// File: tb/wide_reg_gather_tb.sv
module wide_reg_gather_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        merge_err;

  int checks = 0;
  int fails  = 0;

  logic [127:0] m_csr  [8];
  logic [63:0]  m_sram [16];
  logic [3:0]   stg_mask = '0;
  int           stg_tag  = 0;
  logic [127:0] stg_data = '0;
  logic         snap_v   = 1'b0;
  int           snap_tag = 0;
  logic [127:0] snap_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_reg_gather u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .merge_err(merge_err)
  );

  function automatic logic [11:0] csr_a(input int idx, input int dw);
    return 12'(idx * 16 + dw * 4);
  endfunction

  function automatic logic [11:0] sram_a(input int idx, input int dw);
    return 12'(12'h800 + idx * 8 + dw * 4);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d, input string req);
    logic region = a[11];
    int   idx    = region ? int'(a[6:3]) : int'(a[6:4]);
    int   dw     = region ? int'(a[2]) : int'(a[3:2]);
    int   tag    = (region ? 64 : 0) + idx;
    logic exp_err = 1'b0;
    logic hit;
    logic full;
    if (a == 12'h070) begin
      m_csr[7][31:0] = d;
    end else begin
      hit = (stg_mask != 0) && (stg_tag == tag);
      exp_err = (stg_mask != 0) && !hit;
      if (!hit) stg_mask = '0;
      stg_mask[dw] = 1'b1;
      stg_data[dw*32 +: 32] = d;
      stg_tag = tag;
      full = region ? (stg_mask[1:0] == 2'b11) : (stg_mask == 4'hF);
      if (full) begin
        if (region) m_sram[idx] = stg_data[63:0];
        else        m_csr[idx]  = stg_data;
        stg_mask = '0;
      end
    end
    @(negedge clk);
    host_wr = 1'b1; host_rd = 1'b0; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    check(req, 32'(merge_err), 32'(exp_err));
  endtask

  task automatic do_read(input logic [11:0] a, input string req);
    logic region = a[11];
    int   idx    = region ? int'(a[6:3]) : int'(a[6:4]);
    int   dw     = region ? int'(a[2]) : int'(a[3:2]);
    int   tag    = (region ? 64 : 0) + idx;
    logic [127:0] live = region ? {64'b0, m_sram[idx]} : m_csr[idx];
    if (!snap_v || snap_tag != tag || dw == 0) begin
      snap_data = live; snap_tag = tag; snap_v = 1'b1;
      if (!region && idx == 6) m_csr[6] = '0;
    end
    @(negedge clk);
    host_rd = 1'b1; host_wr = 1'b0; host_addr = a;
    @(posedge clk); #1;
    check({req, " rvalid"}, 32'(host_rvalid), 32'd1);
    check(req, host_rdata, snap_data[dw*32 +: 32]);
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
    @(posedge clk); #1;
    check({req, " err pulse end"}, 32'(merge_err), 32'd0);
    check("R6 idle rvalid", 32'(host_rvalid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0042);
    for (int i = 0; i < 8; i++) m_csr[i] = '0;
    for (int i = 0; i < 16; i++) m_sram[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    // R10 reset state
    check("R10 rdata", host_rdata, 32'd0);
    check("R10 rvalid", 32'(host_rvalid), 32'd0);
    check("R10 err", 32'(merge_err), 32'd0);
    do_read(csr_a(0, 0), "R10 csr zero");
    check("R10 csr0 const", host_rdata, 32'd0);

    // R3 fill SRAM, both dwords per word
    for (int i = 0; i < 16; i++) begin
      do_write(sram_a(i, 1), 32'hB000_0000 + i, "R3 w hi");
      do_write(sram_a(i, 0), 32'hA000_0000 + i, "R3 w lo");
    end
    do_read(sram_a(5, 0), "R3 lo");
    check("R3 const lo", host_rdata, 32'hA000_0005);
    do_read(sram_a(5, 1), "R3 hi");
    check("R3 const hi", host_rdata, 32'hB000_0005);

    // R1 partial write leaves register unchanged
    do_write(csr_a(2, 0), 32'h1111_0000, "R1");
    do_write(csr_a(2, 1), 32'h1111_0001, "R1");
    do_write(csr_a(2, 2), 32'h1111_0002, "R1");
    do_read(csr_a(2, 0), "R1 before commit");
    check("R1 old value", host_rdata, 32'd0);
    do_write(csr_a(2, 3), 32'h1111_0003, "R1");
    do_read(csr_a(2, 0), "R1 after commit");
    check("R1 new value", host_rdata, 32'h1111_0000);
    do_read(csr_a(2, 3), "R1 dw3");

    // R2 any order, rewrite replaces
    do_write(csr_a(3, 3), 32'h2222_0003, "R2");
    do_write(csr_a(3, 1), 32'hDEAD_BEEF, "R2");
    do_write(csr_a(3, 1), 32'h2222_0001, "R2");
    do_write(csr_a(3, 0), 32'h2222_0000, "R2");
    do_write(csr_a(3, 2), 32'h2222_0002, "R2");
    do_read(csr_a(3, 0), "R2");
    do_read(csr_a(3, 1), "R2 rewrite");
    check("R2 const", host_rdata, 32'h2222_0001);

    // R4 interleaved write discards and pulses
    do_write(csr_a(4, 0), 32'h4444_0000, "R4");
    do_write(csr_a(5, 0), 32'h5555_0000, "R4 interleave");
    check("R4 err pulse", 32'(merge_err), 32'd1);
    idle("R4");
    for (int d = 1; d < 4; d++) do_write(csr_a(5, d), 32'h5555_0000 + d, "R4");
    do_read(csr_a(4, 0), "R4 discarded");
    check("R4 csr4 untouched", host_rdata, 32'd0);
    do_read(csr_a(5, 3), "R4 csr5");

    // R5 fresh gather after commit
    do_write(csr_a(4, 1), 32'h4444_0001, "R5 fresh no err");
    for (int d = 0; d < 4; d++) if (d != 1) do_write(csr_a(4, d), 32'h4444_0000 + d, "R5");
    do_write(csr_a(0, 2), 32'h0000_0A02, "R5 after commit");
    for (int d = 0; d < 4; d++) if (d != 2) do_write(csr_a(0, d), 32'h0000_0A00 + d, "R5");

    // R7 snapshot served despite later writes
    do_read(csr_a(1, 0), "R7 latch");
    for (int d = 0; d < 4; d++) do_write(csr_a(1, d), 32'h7777_0000 + d, "R7");
    do_read(csr_a(1, 3), "R7 stale");
    check("R7 const", host_rdata, 32'd0);
    do_read(csr_a(1, 0), "R7 refresh");
    check("R7 new", host_rdata, 32'h7777_0000);

    // R8 read-to-clear
    for (int d = 0; d < 4; d++) do_write(csr_a(6, d), 32'h6666_0000 + d, "R8");
    do_read(csr_a(6, 0), "R8 first");
    check("R8 const dw0", host_rdata, 32'h6666_0000);
    do_read(csr_a(6, 2), "R8 snapshot");
    check("R8 const dw2", host_rdata, 32'h6666_0002);
    do_read(csr_a(6, 0), "R8 cleared");
    check("R8 zero", host_rdata, 32'd0);

    // R9 bypass leaves staging alone
    do_write(csr_a(3, 0), 32'h3333_0000, "R9 stage");
    do_write(12'h070, 32'h9999_0000, "R9 bypass");
    do_write(csr_a(3, 1), 32'h3333_0001, "R9 no err");
    do_read(csr_a(7, 0), "R9 bypass value");
    check("R9 const", host_rdata, 32'h9999_0000);
    do_write(csr_a(3, 2), 32'h3333_0002, "R9");
    do_write(csr_a(3, 3), 32'h3333_0003, "R9");
    do_read(csr_a(3, 1), "R9 staged commit");

    // Random mix
    for (int n = 0; n < 500; n++) begin
      int r  = $urandom_range(0, 1);
      int op = $urandom_range(0, 1);
      int ix = r ? $urandom_range(0, 15) : $urandom_range(0, 7);
      int dw = r ? $urandom_range(0, 1) : $urandom_range(0, 3);
      logic [11:0] a = r ? sram_a(ix, dw) : csr_a(ix, dw);
      if (op == 1) do_write(a, $urandom, "R4 random write");
      else         do_read(a, "R6 random read");
    end
    idle("R6");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule